// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block gathers every reason a chip may need to restart: a power-on pulse, a watchdog timeout strobe, a clock-failure strobe and a low level on a shared open-drain reset line. Whatever the cause, it pulls the reset line low for a timed recovery window. It then lets the line go and looks at it again after a short settling delay. A line that is still low means something outside the chip is holding it, so the reset counts as external. A line that has risen means the chip pulled it on its own, and the latched fault flags decide which restart vector address the processor fetches.

Power-on and clock failure both need the oscillator to settle, so the line stays low for a long start-up window before the recovery window begins. A watchdog timeout, or an outside pull on the line while the chip is running, goes straight to the recovery window. The internal reset is entered at once on power-on, with no clock edge needed. It is always released on an oscillator clock edge. The line level passes through a two-flop synchronizer before any decision uses it.

Top module: `rst_sequencer`

## Requirements
- R1: A high level on `por_i` asserts `sys_rst_o` and `pin_pulldown_o` at once, without waiting for a clock edge. It also clears both fault flags and sets `vec_addr_o` to 0xFFFE, so the sequence that follows ends on 0xFFFE unless a new fault arrives.
- R2: After power-on is released, or after a clock-fail strobe, `pin_pulldown_o` stays high for `OSC_DLY` (4096) cycles of start-up delay. The recovery window follows, so the line is low for 4096+16 cycles in total.
- R3: The recovery window drives `pin_pulldown_o` high for `DRIVE_LEN` (16) cycles and then releases it. A watchdog strobe, or a low line seen while running, starts this window directly, with no start-up delay.
- R4: After the line is released, `sys_rst_o` stays high for exactly `SETTLE_LEN` (9) more cycles. The synchronized line is sampled on the last of these cycles.
- R5: If the sampled line is low, the reset counts as external. `vec_addr_o` becomes 0xFFFE and both fault flags are cleared, so a later short line pulse with no new fault also ends on 0xFFFE.
- R6: If the sampled line is high and the clock-fail flag is set, `vec_addr_o` becomes 0xFFFC, even when the watchdog flag is also set. The vector is always one of 0xFFFE, 0xFFFC or 0xFFFA.
- R7: If the sampled line is high, the clock-fail flag is clear and the watchdog flag is set, `vec_addr_o` becomes 0xFFFA. With neither flag set it becomes 0xFFFE.
- R8: `sys_rst_o` stays high until the synchronized line reads high. It falls on that clock edge. While `sys_rst_o` is low, `vec_addr_o` does not change.
- R9: A clock-fail strobe at any time, even on the edge where the sample is taken, restarts the sequence at the start-up delay. A watchdog strobe restarts it at the recovery window. Strobes that arrive together set both flags.
- R10: The line level reaches the control logic through two flops. A low line applied just after edge k raises `sys_rst_o` after edge k+3. A release applied just after edge m lowers it after edge m+3 when the block is waiting on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| wdog_tmo_i | input | 1 | Watchdog timeout strobe, one cycle, synchronous |
| clk_fail_i | input | 1 | Clock-monitor failure strobe, one cycle, synchronous |
| pin_level_i | input | 1 | Level read back from the open-drain reset line (1 = high) |
| pin_pulldown_o | output | 1 | 1 = pull the reset line low |
| sys_rst_o | output | 1 | Internal reset, active high |
| vec_addr_o | output | 16 | Selected restart vector address |

## Verification
Two functions can fall on the same clock edge: the sampling decision that closes the settling window, and a fresh fault strobe that restarts the sequence. The bench pulses a clock-fail strobe exactly 25 edges after a watchdog strobe, which is the edge on which the watchdog sequence would make its decision. It then requires that reset never drops, that the full start-up delay follows, and that the final vector is 0xFFFC, because the watchdog flag must survive the cancelled decision. Watchdog and clock-fail strobes on the same edge are also applied, and that run must end on 0xFFFC. A behavioural model in the bench is compared with all three outputs on every cycle.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/100ps
package rst_seq_pkg;

   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_OSC    = 3'd1,
      ST_DRIVE  = 3'd2,
      ST_SETTLE = 3'd3,
      ST_HOLD   = 3'd4
   } seq_state_e;

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rst_seq_sync.sv
`timescale 1ns/100ps
module rst_seq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or posedge arst) begin
               if (arst) chain_q[0] <= RST_VAL;
               else      chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or posedge arst) begin
               if (arst) chain_q[i] <= RST_VAL;
               else      chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/rst_seq_timer.sv
`timescale 1ns/100ps
module rst_seq_timer #(
   parameter int             CNT_W = 13,
   parameter logic [CNT_W-1:0] INIT = '0
) (
   input  logic             clk,
   input  logic             arst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)                cnt_q <= INIT;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/rst_seq_cause.sv
`timescale 1ns/100ps
module rst_seq_cause #(
   parameter int                ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] VEC_NORMAL = 16'hFFFE,
   parameter logic [ADDR_W-1:0] VEC_CLKMON = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_WDOG   = 16'hFFFA
) (
   input  logic              clk,
   input  logic              arst,
   input  logic              wdog_set,
   input  logic              cmon_set,
   input  logic              decide,
   input  logic              line_high,
   output logic [ADDR_W-1:0] vec
);
   logic wd_flag_q, cm_flag_q;
   logic [ADDR_W-1:0] vec_q, vec_pick;

   // clock-fail outranks watchdog; a low line means external
   always_comb begin
      if (!line_high)     vec_pick = VEC_NORMAL;
      else if (cm_flag_q) vec_pick = VEC_CLKMON;
      else if (wd_flag_q) vec_pick = VEC_WDOG;
      else                vec_pick = VEC_NORMAL;
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         wd_flag_q <= 1'b0;
         cm_flag_q <= 1'b0;
         vec_q     <= VEC_NORMAL;
      end else begin
         if (decide) begin
            wd_flag_q <= 1'b0;
            cm_flag_q <= 1'b0;
            vec_q     <= vec_pick;
         end
         if (wdog_set) wd_flag_q <= 1'b1;
         if (cmon_set) cm_flag_q <= 1'b1;
      end
   end

   assign vec = vec_q;
endmodule

// File: rtl/rst_sequencer.sv
`timescale 1ns/100ps
module rst_sequencer
   import rst_seq_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                OSC_DLY     = 4096,
   parameter int                DRIVE_LEN   = 16,
   parameter int                SETTLE_LEN  = 9,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] VEC_NORMAL  = 16'hFFFE,
   parameter logic [ADDR_W-1:0] VEC_CLKMON  = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_WDOG    = 16'hFFFA
) (
   input  logic              clk,
   input  logic              por_i,
   input  logic              wdog_tmo_i,
   input  logic              clk_fail_i,
   input  logic              pin_level_i,
   output logic              pin_pulldown_o,
   output logic              sys_rst_o,
   output logic [ADDR_W-1:0] vec_addr_o
);
   localparam int MAX_LEN = max_of3(OSC_DLY, DRIVE_LEN, SETTLE_LEN);
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam logic [CNT_W-1:0] OSC_LD    = CNT_W'(OSC_DLY - 1);
   localparam logic [CNT_W-1:0] DRIVE_LD  = CNT_W'(DRIVE_LEN - 1);
   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_LEN - 1);

   generate
      if (OSC_DLY < 1)   begin : g_bad_osc   $error("OSC_DLY must be at least 1");   end
      if (DRIVE_LEN < 1) begin : g_bad_drive $error("DRIVE_LEN must be at least 1"); end
      if (SYNC_STAGES < 2) begin : g_bad_sync $error("SYNC_STAGES must be at least 2"); end
      if (SETTLE_LEN <= SYNC_STAGES) begin : g_bad_settle
         $error("SETTLE_LEN must exceed SYNC_STAGES");
      end
      if (ADDR_W < 2)    begin : g_bad_addr  $error("ADDR_W too small");               end
   endgenerate

   seq_state_e       st_q, st_d;
   logic             line_s;
   logic             tmr_load, tmr_zero, decide;
   logic [CNT_W-1:0] tmr_val;

   rst_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk  (clk),
      .arst (por_i),
      .d    (pin_level_i),
      .q    (line_s)
   );

   rst_seq_timer #(.CNT_W(CNT_W), .INIT(OSC_LD)) u_timer (
      .clk      (clk),
      .arst     (por_i),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   rst_seq_cause #(
      .ADDR_W(ADDR_W), .VEC_NORMAL(VEC_NORMAL),
      .VEC_CLKMON(VEC_CLKMON), .VEC_WDOG(VEC_WDOG)
   ) u_cause (
      .clk       (clk),
      .arst      (por_i),
      .wdog_set  (wdog_tmo_i),
      .cmon_set  (clk_fail_i),
      .decide    (decide),
      .line_high (line_s),
      .vec       (vec_addr_o)
   );

   // a fault strobe always wins over the phase logic, including the decision edge
   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      decide   = 1'b0;
      if (clk_fail_i) begin
         st_d = ST_OSC;    tmr_load = 1'b1; tmr_val = OSC_LD;
      end else if (wdog_tmo_i) begin
         st_d = ST_DRIVE;  tmr_load = 1'b1; tmr_val = DRIVE_LD;
      end else begin
         unique case (st_q)
            ST_RUN: if (!line_s) begin
               st_d = ST_DRIVE; tmr_load = 1'b1; tmr_val = DRIVE_LD;
            end
            ST_OSC: if (tmr_zero) begin
               st_d = ST_DRIVE; tmr_load = 1'b1; tmr_val = DRIVE_LD;
            end
            ST_DRIVE: if (tmr_zero) begin
               st_d = ST_SETTLE; tmr_load = 1'b1; tmr_val = SETTLE_LD;
            end
            ST_SETTLE: if (tmr_zero) begin
               decide = 1'b1;
               st_d   = line_s ? ST_RUN : ST_HOLD;
            end
            ST_HOLD: if (line_s) st_d = ST_RUN;
            default: st_d = ST_OSC;
         endcase
      end
   end

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i) st_q <= ST_OSC;
      else       st_q <= st_d;
   end

   assign pin_pulldown_o = (st_q == ST_OSC) || (st_q == ST_DRIVE);
   assign sys_rst_o      = (st_q != ST_RUN);
endmodule

// File: rtl/rst_sequencer_chk.sv
`timescale 1ns/100ps
module rst_sequencer_chk #(
   parameter int                ADDR_W     = 16,
   parameter int                DRIVE_LEN  = 16,
   parameter logic [ADDR_W-1:0] VEC_NORMAL = 16'hFFFE,
   parameter logic [ADDR_W-1:0] VEC_CLKMON = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_WDOG   = 16'hFFFA
) (
   input logic              clk,
   input logic              por_i,
   input logic              wdog_tmo_i,
   input logic              clk_fail_i,
   input logic              pin_level_i,
   input logic              pin_pulldown_o,
   input logic              sys_rst_o,
   input logic [ADDR_W-1:0] vec_addr_o
);
   logic [15:0] pd_run_q;

   always_ff @(posedge clk or posedge por_i) begin
      if (por_i)               pd_run_q <= '0;
      else if (!pin_pulldown_o) pd_run_q <= '0;
      else if (pd_run_q != 16'hFFFF) pd_run_q <= pd_run_q + 16'd1;
   end

   assert_pd_in_rst_R3: assert property (@(posedge clk) disable iff (por_i)
      pin_pulldown_o |-> sys_rst_o);

   assert_drive_min_R3: assert property (@(posedge clk) disable iff (por_i)
      $fell(pin_pulldown_o) |-> (pd_run_q >= 16'(DRIVE_LEN)));

   assert_settle_rst_R4: assert property (@(posedge clk) disable iff (por_i)
      $fell(pin_pulldown_o) |-> sys_rst_o);

   assert_vec_legal_R6: assert property (@(posedge clk) disable iff (por_i)
      (vec_addr_o == VEC_NORMAL) || (vec_addr_o == VEC_CLKMON) || (vec_addr_o == VEC_WDOG));

   assert_vec_hold_R8: assert property (@(posedge clk) disable iff (por_i)
      (!sys_rst_o && $past(!sys_rst_o)) |-> $stable(vec_addr_o));

   assert_release_line_R8: assert property (@(posedge clk) disable iff (por_i)
      $fell(sys_rst_o) |-> $past(pin_level_i, 3));

   assert_cfail_restart_R9: assert property (@(posedge clk) disable iff (por_i)
      clk_fail_i |=> (pin_pulldown_o && sys_rst_o));

   assert_wdog_restart_R9: assert property (@(posedge clk) disable iff (por_i)
      wdog_tmo_i |=> pin_pulldown_o);
endmodule

bind rst_sequencer rst_sequencer_chk #(
   .ADDR_W(ADDR_W), .DRIVE_LEN(DRIVE_LEN), .VEC_NORMAL(VEC_NORMAL),
   .VEC_CLKMON(VEC_CLKMON), .VEC_WDOG(VEC_WDOG)
) u_chk (
   .clk            (clk),
   .por_i          (por_i),
   .wdog_tmo_i     (wdog_tmo_i),
   .clk_fail_i     (clk_fail_i),
   .pin_level_i    (pin_level_i),
   .pin_pulldown_o (pin_pulldown_o),
   .sys_rst_o      (sys_rst_o),
   .vec_addr_o     (vec_addr_o)
);

// File: tb/tb_rst_sequencer.sv
`timescale 1ns/100ps
module tb_rst_sequencer;
   localparam int OSC = 4096;
   localparam int DRV = 16;
   localparam int SMP = 9;
   localparam logic [15:0] V_NORM = 16'hFFFE;
   localparam logic [15:0] V_CMON = 16'hFFFC;
   localparam logic [15:0] V_WDOG = 16'hFFFA;

   logic clk = 1'b0;
   logic por = 1'b0, wd = 1'b0, cf = 1'b0, ext_low = 1'b0;
   logic pin_level, pin_pd, rst;
   logic [15:0] vec;

   int n_chk = 0, n_err = 0, cyc = 0;
   bit cmp_en = 1'b0;

   always #2.5 clk = ~clk;

   assign pin_level = !(pin_pd || ext_low);

   rst_sequencer dut (
      .clk(clk), .por_i(por), .wdog_tmo_i(wd), .clk_fail_i(cf),
      .pin_level_i(pin_level), .pin_pulldown_o(pin_pd),
      .sys_rst_o(rst), .vec_addr_o(vec)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          m_ph;    // 0 running, 1 start-up, 2 drive, 3 settle, 4 wait line
   int          m_rem;
   bit          m_pd, m_rst, m_fwd, m_fcm, m_s1, m_s2;
   logic [15:0] m_vec;

   always @(posedge clk or posedge por) begin
      if (por) begin
         m_ph = 1; m_rem = OSC; m_fwd = 0; m_fcm = 0;
         m_vec = V_NORM; m_s1 = 0; m_s2 = 0;
      end else begin : step
         bit line_now, seen;
         line_now = !(m_pd || ext_low);
         seen = m_s2;
         m_s2 = m_s1;
         m_s1 = line_now;
         if (cf) m_fcm = 1;
         if (wd) m_fwd = 1;
         if (cf) begin
            m_ph = 1; m_rem = OSC;
         end else if (wd) begin
            m_ph = 2; m_rem = DRV;
         end else begin
            case (m_ph)
               0: if (!seen) begin m_ph = 2; m_rem = DRV; end
               1: begin m_rem--; if (m_rem == 0) begin m_ph = 2; m_rem = DRV; end end
               2: begin m_rem--; if (m_rem == 0) begin m_ph = 3; m_rem = SMP; end end
               3: begin
                  m_rem--;
                  if (m_rem == 0) begin
                     if (seen) begin
                        m_vec = m_fcm ? V_CMON : (m_fwd ? V_WDOG : V_NORM);
                        m_ph = 0;
                     end else begin
                        m_vec = V_NORM;
                        m_ph = 4;
                     end
                     m_fcm = 0; m_fwd = 0;
                  end
               end
               4: if (seen) m_ph = 0;
               default: m_ph = 1;
            endcase
         end
      end
      m_pd  = (m_ph == 1) || (m_ph == 2);
      m_rst = (m_ph != 0);
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk(pin_pd === m_pd,  "R3", "model pulldown", pin_pd, m_pd);
         chk(rst    === m_rst, "R8", "model reset",    rst,    m_rst);
         chk(vec    === m_vec, "R6", "model vector",   vec,    m_vec);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_err++;
         $display("FAIL R8 watchdog: cycles %0d expected below %0d", cyc, 150000);
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   // ---------------- helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse(input bit do_wd, input bit do_cf);
      @(posedge clk); #1;
      wd = do_wd; cf = do_cf;
      @(posedge clk); #1;
      wd = 1'b0; cf = 1'b0;
   endtask

   task automatic measure(output int n_pd, output int n_settle);
      n_pd = 0; n_settle = 0;
      forever begin
         @(negedge clk);
         if (pin_pd) n_pd++;
         else if (rst) n_settle++;
         else break;
         if (n_pd + n_settle > 20000) break;
      end
      @(posedge clk); #1;
   endtask

   task automatic wait_run();
      int guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (rst && guard < 20000);
      @(posedge clk); #1;
   endtask

   // ---------------- stimulus ----------------
   initial begin : main
      int np, ns;

      // power-on, async entry before any clock edge
      #1 por = 1'b1;
      #0.5;
      chk(rst === 1'b1,    "R1", "async reset at power-on", rst, 1);
      chk(pin_pd === 1'b1, "R1", "async pulldown at power-on", pin_pd, 1);
      cmp_en = 1'b1;
      tick(3);
      por = 1'b0;
      measure(np, ns);
      chk(np == OSC + DRV, "R2", "power-on pulldown cycles", np, OSC + DRV);
      chk(ns == SMP,       "R4", "settle cycles after release", ns, SMP);
      chk(vec === V_NORM,  "R7", "no-fault vector", vec, V_NORM);

      // watchdog: no start-up delay
      pulse(1'b1, 1'b0);
      measure(np, ns);
      chk(np == DRV,       "R3", "watchdog pulldown cycles", np, DRV);
      chk(ns == SMP,       "R4", "watchdog settle cycles", ns, SMP);
      chk(vec === V_WDOG,  "R7", "watchdog vector", vec, V_WDOG);
      tick(20);
      chk(vec === V_WDOG,  "R8", "vector held while running", vec, V_WDOG);

      // clock failure
      pulse(1'b0, 1'b1);
      measure(np, ns);
      chk(np == OSC + DRV, "R2", "clock-fail pulldown cycles", np, OSC + DRV);
      chk(vec === V_CMON,  "R6", "clock-fail vector", vec, V_CMON);

      // both strobes together
      pulse(1'b1, 1'b1);
      measure(np, ns);
      chk(np == OSC + DRV, "R9", "joint strobe pulldown cycles", np, OSC + DRV);
      chk(vec === V_CMON,  "R6", "clock-fail outranks watchdog", vec, V_CMON);

      // watchdog then clock failure during drive: restart with start-up delay
      pulse(1'b1, 1'b0);
      tick(5);
      pulse(1'b0, 1'b1);
      measure(np, ns);
      chk(np == OSC + DRV, "R9", "restart from drive", np, OSC + DRV);
      chk(vec === V_CMON,  "R9", "vector after restart", vec, V_CMON);

      // watchdog again inside the settle window
      pulse(1'b1, 1'b0);
      tick(DRV + 3);
      pulse(1'b1, 1'b0);
      measure(np, ns);
      chk(np == DRV,       "R9", "watchdog restart in settle", np, DRV);
      chk(vec === V_WDOG,  "R7", "vector after settle restart", vec, V_WDOG);

      // external hold of the line
      @(posedge clk); #1;
      ext_low = 1'b1;
      repeat (3) @(negedge clk);
      chk(rst === 1'b0, "R10", "reset not yet raised two edges after line low", rst, 0);
      @(negedge clk);
      chk(rst === 1'b1, "R10", "reset raised three edges after line low", rst, 1);
      tick(60);
      chk(rst === 1'b1,   "R8", "reset held while line low", rst, 1);
      chk(vec === V_NORM, "R5", "external vector", vec, V_NORM);
      @(posedge clk); #1;
      ext_low = 1'b0;
      repeat (3) @(negedge clk);
      chk(rst === 1'b1, "R10", "reset still high two edges after release", rst, 1);
      @(negedge clk);
      chk(rst === 1'b0, "R8", "reset falls when line reads high", rst, 0);
      tick(1);

      // clock failure hidden by an external hold: flags must be cleared
      pulse(1'b0, 1'b1);
      ext_low = 1'b1;
      tick(OSC + DRV + SMP + 20);
      chk(rst === 1'b1,   "R5", "held line keeps reset", rst, 1);
      chk(vec === V_NORM, "R5", "external wins over clock fail", vec, V_NORM);
      ext_low = 1'b0;
      wait_run();
      @(posedge clk); #1;
      ext_low = 1'b1;
      @(posedge clk); #1;
      ext_low = 1'b0;
      wait_run();
      chk(vec === V_NORM, "R5", "flags cleared by external decision", vec, V_NORM);

      // decision edge collides with a clock-fail strobe
      pulse(1'b1, 1'b0);
      repeat (DRV + SMP - 1) @(posedge clk);
      #1;
      cf = 1'b1;
      @(posedge clk); #1;
      cf = 1'b0;
      chk(rst === 1'b1, "R9", "reset kept on collision edge", rst, 1);
      measure(np, ns);
      chk(np == OSC + DRV, "R9", "collision restart pulldown", np, OSC + DRV);
      chk(vec === V_CMON,  "R9", "watchdog flag survives, clock fail wins", vec, V_CMON);

      // power-on while running, then power-on clearing a fresh watchdog flag
      @(posedge clk); #1;
      por = 1'b1;
      #1;
      chk(rst === 1'b1,    "R1", "async reset from running", rst, 1);
      chk(vec === V_NORM,  "R1", "vector reset by power-on", vec, V_NORM);
      tick(2);
      por = 1'b0;
      wait_run();
      pulse(1'b1, 1'b0);
      wait_run();
      chk(vec === V_WDOG, "R7", "watchdog vector before power-on", vec, V_WDOG);
      pulse(1'b1, 1'b0);
      tick(3);
      por = 1'b1;
      tick(2);
      por = 1'b0;
      wait_run();
      chk(vec === V_NORM, "R1", "power-on clears watchdog flag", vec, V_NORM);

      tick(5);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule